// File: doc/BRIEF.md
# Halt wake controller

This block sequences the low-power halt of a small microcontroller. When the decoder reports a HALT instruction, the block either drops the request or honours it. It drops the request if the watchdog is running. If it honours the request, it turns off the oscillator enable, the CPU clock enable and the peripheral clock enable together. While halted, the block watches two wake sources: a rising edge on the external interrupt line, which passes through a synchronizer first, and an external reset request.

On a wake event the oscillator comes back at once. The CPU and peripheral clocks stay off through a fixed stabilization count. When the count ends, the clocks return together with a one-cycle resume pulse and a 2-bit code. The code tells the core whether to:
- continue after the HALT,
- enter the external interrupt routine, or
- fetch the reset vector.

Wake-up never depends on the interrupt mask. The mask only picks between the first two resume choices.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it is released, `osc_en`, `cpu_clk_en` and `per_clk_en` are high and `resume_vld` is low.
- R2: A `halt_req` sampled while `wdog_en` is high has no effect. All three enables stay high on the following cycle and no resume pulse is produced.
- R3: A `halt_req` sampled in normal operation with `wdog_en` low drives `osc_en`, `cpu_clk_en` and `per_clk_en` low from the next cycle on.
- R4: While halted, `ext_irq_raw` passes through a two-flop synchronizer. Only a rising edge wakes the block, and `osc_en` returns after the third clock edge following the rise. An interrupt line that was already high when the halt began does not wake the block.
- R5: Wake-up on an interrupt edge happens for both values of `irq_mask`.
- R6: From the wake event, `osc_en` is high. `cpu_clk_en` and `per_clk_en` stay low for exactly STAB_CYCLES (4096) cycles and rise on the following cycle.
- R7: After an interrupt wake, `resume_code` is 2'b01 (next instruction) if `irq_mask` is 1 in the last stabilization cycle. It is 2'b10 (interrupt service) if `irq_mask` is 0 then.
- R8: An `ext_rst` sampled while halted ends the halt: `osc_en` is high on the next cycle and the resume code is 2'b11 (reset vector).
- R9: `resume_vld` is a single-cycle pulse issued in the cycle the clocks come back. Outside that pulse `resume_code` reads 2'b00.
- R10: If `ext_rst` and a synchronized interrupt edge arrive in the same halted cycle, the reset wins and the resume code is 2'b11.
- R11: An `ext_rst` during stabilization restarts the full STAB_CYCLES count and forces the resume code to 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock of the sequencer |
| rst_n | input | 1 | Asynchronous active-low block reset |
| halt_req | input | 1 | One-cycle strobe: HALT instruction decoded |
| wdog_en | input | 1 | Watchdog running; HALT requests are dropped |
| ext_irq_raw | input | 1 | Asynchronous external interrupt line |
| irq_mask | input | 1 | External interrupt mask, 1 = masked |
| ext_rst | input | 1 | Synchronous external reset request, a wake source |
| osc_en | output | 1 | Oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| resume_vld | output | 1 | One-cycle pulse: the core may resume |
| resume_code | output | 2 | 01 next instruction, 10 interrupt service, 11 reset vector, 00 idle |

## Verification
Two cases are the hardest to bring about from the ports:
- A reset and an interrupt edge landing in the same halted cycle. Because of the synchronizer, the edge reaches the state machine two clock edges after the raw line rises. The stimulus raises the raw line, waits out exactly those two edges, and then pulses `ext_rst` so that both events are sampled together.
- A reset during stabilization. The bench lets an interrupt wake run about a thousand cycles into the count, pulses `ext_rst`, and then times a complete new 4096-cycle window before the clocks may return.

A scoreboard queue holds the expected resume codes and checks them against every resume pulse.

// File: rtl/hwc_pkg.sv
package hwc_pkg;

  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALTED = 2'd1,
    ST_STAB   = 2'd2,
    ST_RESUME = 2'd3
  } hwc_state_e;

  localparam logic [1:0] RC_NONE = 2'b00;
  localparam logic [1:0] RC_NEXT = 2'b01;
  localparam logic [1:0] RC_ISR  = 2'b10;
  localparam logic [1:0] RC_RSTV = 2'b11;

endpackage

// File: rtl/hwc_irq_sync.sv
module hwc_irq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic irq_raw,
  output logic irq_rise
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;
  logic              prev_q;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], irq_raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign irq_rise = sync_q[STAGES-1] & ~prev_q;

  // R4
  single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rise |=> !irq_rise)
    else $error("irq rise indication lasted more than one cycle");

endmodule

// File: rtl/hwc_stab_timer.sv
module hwc_stab_timer #(
  parameter int STAB_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic done
);

  localparam int CW = (STAB_CYCLES > 2) ? $clog2(STAB_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STAB_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | run;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = run && (cnt_q == LAST);

  // R6
  stab_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr && !done) |=> (cnt_q == $past(cnt_q) + 1'b1))
    else $error("stabilization counter skipped a step");

  // R11
  stab_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0))
    else $error("stabilization counter not restarted");

endmodule

// File: rtl/hwc_fsm.sv
module hwc_fsm
  import hwc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       wdog_en,
  input  logic       irq_rise,
  input  logic       irq_mask,
  input  logic       ext_rst,
  input  logic       tmr_done,
  output logic       tmr_clr,
  output logic       tmr_run,
  output logic       osc_en,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       resume_vld,
  output logic [1:0] resume_code
);

  hwc_state_e state_q, state_d;
  logic       cause_rst_q, cause_rst_d;
  logic [1:0] code_q, code_d;

  always_comb begin
    state_d     = state_q;
    cause_rst_d = cause_rst_q;
    code_d      = code_q;
    tmr_clr     = 1'b0;
    unique case (state_q)
      ST_RUN: begin
        if (halt_req && !wdog_en) state_d = ST_HALTED;
      end
      ST_HALTED: begin
        if (ext_rst) begin
          state_d     = ST_STAB;
          cause_rst_d = 1'b1;
          tmr_clr     = 1'b1;
        end else if (irq_rise) begin
          state_d     = ST_STAB;
          cause_rst_d = 1'b0;
          tmr_clr     = 1'b1;
        end
      end
      ST_STAB: begin
        if (ext_rst) begin
          cause_rst_d = 1'b1;
          tmr_clr     = 1'b1;
        end else if (tmr_done) begin
          state_d = ST_RESUME;
          code_d  = cause_rst_q ? RC_RSTV : (irq_mask ? RC_NEXT : RC_ISR);
        end
      end
      ST_RESUME: begin
        if (ext_rst) begin
          state_d     = ST_STAB;
          cause_rst_d = 1'b1;
          tmr_clr     = 1'b1;
        end else begin
          state_d = ST_RUN;
        end
      end
      default: state_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_RUN;
      cause_rst_q <= 1'b0;
      code_q      <= RC_NONE;
    end else begin
      state_q     <= state_d;
      cause_rst_q <= cause_rst_d;
      code_q      <= code_d;
    end
  end

  always_comb begin
    tmr_run     = (state_q == ST_STAB);
    osc_en      = (state_q != ST_HALTED);
    cpu_clk_en  = (state_q == ST_RUN) || (state_q == ST_RESUME);
    per_clk_en  = cpu_clk_en;
    resume_vld  = (state_q == ST_RESUME);
    resume_code = resume_vld ? code_q : RC_NONE;
  end

  // R2
  wdog_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && halt_req && wdog_en) |=> (osc_en && cpu_clk_en && per_clk_en))
    else $error("HALT honoured while watchdog running");

  // R3
  halt_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && halt_req && !wdog_en) |=> (!osc_en && !cpu_clk_en && !per_clk_en))
    else $error("accepted HALT did not gate clocks");

  // R5
  mask_free_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALTED && irq_rise && !ext_rst) |=> (state_q == ST_STAB && osc_en))
    else $error("interrupt edge did not wake");

  // R10
  rst_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_RUN && ext_rst) |=> (state_q == ST_STAB && cause_rst_q))
    else $error("reset wake not taken");

  // R6
  clk_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en) |-> resume_vld)
    else $error("clocks returned without resume pulse");

  // R9
  resume_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resume_vld |=> !resume_vld)
    else $error("resume pulse longer than one cycle");

endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl #(
  parameter int STAB_CYCLES = 4096,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       wdog_en,
  input  logic       ext_irq_raw,
  input  logic       irq_mask,
  input  logic       ext_rst,
  output logic       osc_en,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       resume_vld,
  output logic [1:0] resume_code
);

  logic irq_rise;
  logic tmr_clr;
  logic tmr_run;
  logic tmr_done;

  hwc_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_raw  (ext_irq_raw),
    .irq_rise (irq_rise)
  );

  hwc_stab_timer #(.STAB_CYCLES(STAB_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .run   (tmr_run),
    .done  (tmr_done)
  );

  hwc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .halt_req    (halt_req),
    .wdog_en     (wdog_en),
    .irq_rise    (irq_rise),
    .irq_mask    (irq_mask),
    .ext_rst     (ext_rst),
    .tmr_done    (tmr_done),
    .tmr_clr     (tmr_clr),
    .tmr_run     (tmr_run),
    .osc_en      (osc_en),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .resume_vld  (resume_vld),
    .resume_code (resume_code)
  );

endmodule

// File: tb/halt_wake_ctrl_test.sv
`timescale 1ns/1ps
module halt_wake_ctrl_test;

  localparam int STAB = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 1'b0;
  logic wdog_en = 1'b0;
  logic ext_irq_raw = 1'b0;
  logic irq_mask = 1'b0;
  logic ext_rst = 1'b0;
  logic osc_en, cpu_clk_en, per_clk_en, resume_vld;
  logic [1:0] resume_code;

  int n_checks = 0;
  int n_fail = 0;
  logic [1:0] exp_q[$];

  always #2 clk = ~clk;

  halt_wake_ctrl uut (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .wdog_en(wdog_en),
    .ext_irq_raw(ext_irq_raw), .irq_mask(irq_mask), .ext_rst(ext_rst),
    .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .resume_vld(resume_vld), .resume_code(resume_code)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor: pops the scoreboard on every resume pulse (R7, R8, R9)
  always @(negedge clk) begin
    if (rst_n && resume_vld) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected resume pulse, code", resume_code, 0);
      end else begin
        automatic logic [1:0] e = exp_q.pop_front();
        check(resume_code == e, "R7/R8", "resume code", resume_code, e);
      end
    end
  end

  function automatic int enables();
    return {29'd0, osc_en, cpu_clk_en, per_clk_en};
  endfunction

  task automatic do_halt(input string req);
    @(negedge clk) halt_req = 1'b1;
    @(negedge clk) halt_req = 1'b0;
    check(enables() == 0, req, "enables after accepted HALT", enables(), 0);
  endtask

  // called at the negedge right after the wake edge
  task automatic run_stab(input string req);
    check(osc_en && !cpu_clk_en && !per_clk_en, "R6", "enables at wake", enables(), 4);
    repeat (STAB - 1) @(negedge clk);
    check(!cpu_clk_en && !per_clk_en, "R6", "cpu clock in last stab cycle", cpu_clk_en, 0);
    @(negedge clk);
    check(cpu_clk_en && per_clk_en && resume_vld, req, "clocks back with pulse", enables(), 7);
    @(negedge clk);
    check(!resume_vld && resume_code == 2'b00, "R9", "pulse ended, code", resume_code, 0);
  endtask

  task automatic wake_irq();
    @(negedge clk) ext_irq_raw = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!osc_en, "R4", "osc before sync delay", osc_en, 0);
    @(negedge clk);
    check(osc_en, "R4", "osc after third edge", osc_en, 1);
  endtask

  task automatic finish_run();
    check(exp_q.size() == 0, "R9", "scoreboard items left", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(enables() == 7 && !resume_vld, "R1", "enables during reset", enables(), 7);
    rst_n = 1'b1;
    @(negedge clk);
    check(enables() == 7 && !resume_vld, "R1", "enables after reset", enables(), 7);

    // R2 halt dropped with watchdog running
    wdog_en = 1'b1;
    @(negedge clk) halt_req = 1'b1;
    @(negedge clk) halt_req = 1'b0;
    check(enables() == 7 && !resume_vld, "R2", "enables after dropped HALT", enables(), 7);
    repeat (3) @(negedge clk);
    check(enables() == 7, "R2", "still running", enables(), 7);
    wdog_en = 1'b0;

    // R3 + R5 + R7: masked interrupt wakes, resume at next instruction
    irq_mask = 1'b1;
    do_halt("R3");
    repeat (20) @(negedge clk);
    check(enables() == 0, "R4", "stays halted without event", enables(), 0);
    exp_q.push_back(2'b01);
    wake_irq();
    run_stab("R5");
    ext_irq_raw = 1'b0;

    // R7 unmasked: interrupt service
    irq_mask = 1'b0;
    repeat (4) @(negedge clk);
    do_halt("R3");
    exp_q.push_back(2'b10);
    wake_irq();
    run_stab("R7");
    ext_irq_raw = 1'b0;

    // R8 reset wake
    repeat (4) @(negedge clk);
    do_halt("R3");
    exp_q.push_back(2'b11);
    @(negedge clk) ext_rst = 1'b1;
    @(negedge clk) ext_rst = 1'b0;
    check(osc_en, "R8", "osc after reset wake", osc_en, 1);
    run_stab("R8");

    // R10 simultaneous reset and interrupt edge
    repeat (2) @(negedge clk);
    do_halt("R3");
    exp_q.push_back(2'b11);
    @(negedge clk) ext_irq_raw = 1'b1;
    @(negedge clk);
    @(negedge clk) ext_rst = 1'b1;
    @(negedge clk) ext_rst = 1'b0;
    check(osc_en, "R10", "osc after joint wake", osc_en, 1);
    run_stab("R10");
    ext_irq_raw = 1'b0;

    // R11 reset during stabilization restarts count
    repeat (4) @(negedge clk);
    do_halt("R3");
    exp_q.push_back(2'b11);
    wake_irq();
    repeat (1000) @(negedge clk);
    ext_rst = 1'b1;
    @(negedge clk) ext_rst = 1'b0;
    run_stab("R11");

    // R4: line already high at halt does not wake
    ext_irq_raw = 1'b1;
    repeat (5) @(negedge clk);
    do_halt("R3");
    repeat (20) @(negedge clk);
    check(enables() == 0, "R4", "level-high line did not wake", enables(), 0);
    exp_q.push_back(2'b11);
    ext_rst = 1'b1;
    @(negedge clk) ext_rst = 1'b0;
    run_stab("R8");

    finish_run();
  end

endmodule